// File: doc/BRIEF.md
# Instruction Condition Evaluation Unit

This block sits between instruction decode and commit. Every cycle it takes the 4-bit condition field of the current 32-bit instruction word and the stored N, Z, C and V status flags. From these it decides whether the instruction may commit. An instruction that fails its condition is turned into a no-operation: its register write, its memory write and its flag update are all gated off, and a suppress output is raised.

The block keeps the status flags in a register of its own. A flag-setting instruction, such as a compare, presents its new flag values together with a flag-write enable. If that instruction commits, the register takes the new values at the clock edge, so the next instruction is evaluated against them. The top code of the field is not a "never" condition. It tags an instruction class that always executes, and the block signals that class on a separate output.

Top module: `cond_eval_unit`

## Requirements
- R1: The condition field is instr[31:28]. Its bits [3:1] pick a base test: 000 Z set; 001 C set; 010 N set; 011 V set; 100 C set and Z clear; 101 N equal to V; 110 Z clear and N equal to V; 111 always true. For codes 0000 to 1101, cond_pass is the base test when bit 0 is 0 and its complement when bit 0 is 1. For example, 0000 passes when Z=1 and 0001 passes when Z=0.
- R2: For each code pair 2k/2k+1 with k from 0 to 6, cond_pass of the two codes is complementary for every flag combination.
- R3: Code 1110 gives cond_pass=1 and uncond_class=0 for every flag combination.
- R4: Code 1111 gives uncond_class=1 and cond_pass=1 for every flag combination. It is never treated as "never".
- R5: commit_en equals valid AND (cond_pass OR uncond_class). With valid=0, commit_en is 0.
- R6: rd_we equals commit_en AND rd_we_req, and st_we equals commit_en AND st_we_req. suppress equals valid AND NOT commit_en.
- R7: flags_q ({N,Z,C,V} in bits 3..0) loads flag_new at the clock edge when commit_en and flag_we are both 1. Otherwise it holds, including when a failing instruction requests a flag write. The new value is visible to the instruction in the next cycle.
- R8: A synchronous active-high rst clears flags_q to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | The instruction word is a real instruction this cycle |
| instr | input | 32 | Instruction word; the condition field is bits 31:28 |
| flag_we | input | 1 | The instruction wants to update the flags |
| flag_new | input | 4 | New {N,Z,C,V} from the flag-setting result |
| rd_we_req | input | 1 | The instruction wants to write a register |
| st_we_req | input | 1 | The instruction wants to write memory |
| cond_pass | output | 1 | The condition test passes against flags_q |
| uncond_class | output | 1 | The condition field is 1111 (always-execute class) |
| commit_en | output | 1 | The instruction commits |
| rd_we | output | 1 | Gated register write enable |
| st_we | output | 1 | Gated memory write enable |
| suppress | output | 1 | A valid instruction is squashed to a no-operation |
| flags_q | output | 4 | Stored {N,Z,C,V} flags |

## Verification
The assertions check several rules on every cycle: codes 1110 and 1111 always pass, and 1111 always raises the class flag. No write enable reaches the outputs without a commit, and a squashed instruction leaves the flags unchanged while a committed flag write lands one cycle later. The bench sweeps all sixteen codes against all sixteen flag settings and checks the complementary pairs. Only that scenario work can show that every base test is decoded correctly. The same holds for the compare followed by two conditional writes: they clamp a counter at ten, and this shows that flags written by one instruction steer the next.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
   localparam int FLAG_W = 4;
   localparam int CODE_W = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   // base-test selector taken from the upper three code bits
   typedef enum logic [2:0] {
      BT_ZERO  = 3'd0,
      BT_CARRY = 3'd1,
      BT_NEG   = 3'd2,
      BT_OVF   = 3'd3,
      BT_UHI   = 3'd4,
      BT_SGE   = 3'd5,
      BT_SGT   = 3'd6,
      BT_ALL   = 3'd7
   } base_sel_e;
endpackage

// File: rtl/cond_decode.sv
module cond_decode
   import cond_eval_pkg::*;
#(
   parameter int CODE_BITS = 4
) (
   input  logic [CODE_BITS-1:0] code,
   input  flags_t               flg,
   output logic                 pass,
   output logic                 uncond
);
   localparam logic [CODE_BITS-1:0] UNCOND_CODE = '1;

   if (CODE_BITS != CODE_W) begin : g_bad_width
      $error("cond_decode: CODE_BITS must be 4");
   end

   base_sel_e sel;
   logic      base_ok;
   logic      is_all;

   assign sel    = base_sel_e'(code[CODE_BITS-1:1]);
   assign is_all = (sel == BT_ALL);

   always_comb begin
      unique case (sel)
         BT_ZERO:  base_ok = flg.z;
         BT_CARRY: base_ok = flg.c;
         BT_NEG:   base_ok = flg.n;
         BT_OVF:   base_ok = flg.v;
         BT_UHI:   base_ok = flg.c & ~flg.z;
         BT_SGE:   base_ok = ~(flg.n ^ flg.v);
         BT_SGT:   base_ok = ~flg.z & ~(flg.n ^ flg.v);
         default:  base_ok = 1'b1;
      endcase
   end

   // the inversion bit is ignored for the top base test
   assign pass   = is_all ? 1'b1 : (base_ok ^ code[0]);
   assign uncond = (code == UNCOND_CODE);
endmodule

// File: rtl/flag_store.sv
module flag_store
   import cond_eval_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   if (WIDTH != FLAG_W) begin : g_bad_width
      $error("flag_store: WIDTH must match the flag count");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)       q[i] <= 1'b0;
         else if (load) q[i] <= din[i];
      end
   end

   a_r7_load_lands: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(din)));
   a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
endmodule

// File: rtl/commit_gate.sv
module commit_gate (
   input  logic clk,
   input  logic rst,
   input  logic valid,
   input  logic pass,
   input  logic uncond,
   input  logic flag_req,
   input  logic rd_req,
   input  logic st_req,
   output logic commit,
   output logic flag_load,
   output logic rd_we,
   output logic st_we,
   output logic squash
);
   assign commit    = valid & (pass | uncond);
   assign squash    = valid & ~commit;
   assign flag_load = commit & flag_req;
   assign rd_we     = commit & rd_req;
   assign st_we     = commit & st_req;

   a_r5_idle_no_commit: assert property (@(posedge clk) disable iff (rst)
      !valid |-> !commit && !rd_we && !st_we && !flag_load && !squash);
   a_r6_squash_blocks_writes: assert property (@(posedge clk) disable iff (rst)
      squash |-> !rd_we && !st_we && !flag_load);
   a_r4_uncond_commits: assert property (@(posedge clk) disable iff (rst)
      (valid && uncond) |-> commit);
endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
   import cond_eval_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int COND_LSB = 28
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic               flag_we,
   input  logic [3:0]         flag_new,
   input  logic               rd_we_req,
   input  logic               st_we_req,
   output logic               cond_pass,
   output logic               uncond_class,
   output logic               commit_en,
   output logic               rd_we,
   output logic               st_we,
   output logic               suppress,
   output logic [3:0]         flags_q
);
   localparam int COND_MSB = COND_LSB + CODE_W - 1;

   if (COND_MSB >= INSTR_W) begin : g_bad_field
      $error("cond_eval_unit: condition field lies outside the word");
   end

   logic [CODE_W-1:0] code;
   logic              flag_load;
   flags_t            cur_flags;

   assign code      = instr[COND_MSB:COND_LSB];
   assign cur_flags = flags_t'(flags_q);

   cond_decode #(.CODE_BITS(CODE_W)) u_dec (
      .code   (code),
      .flg    (cur_flags),
      .pass   (cond_pass),
      .uncond (uncond_class)
   );

   commit_gate u_gate (
      .clk       (clk),
      .rst       (rst),
      .valid     (valid),
      .pass      (cond_pass),
      .uncond    (uncond_class),
      .flag_req  (flag_we),
      .rd_req    (rd_we_req),
      .st_req    (st_we_req),
      .commit    (commit_en),
      .flag_load (flag_load),
      .rd_we     (rd_we),
      .st_we     (st_we),
      .squash    (suppress)
   );

   flag_store #(.WIDTH(FLAG_W)) u_flags (
      .clk  (clk),
      .rst  (rst),
      .load (flag_load),
      .din  (flag_new),
      .q    (flags_q)
   );

   a_r3_always_passes: assert property (@(posedge clk) disable iff (rst)
      (code == 4'b1110) |-> cond_pass && !uncond_class);
   a_r4_top_code_class: assert property (@(posedge clk) disable iff (rst)
      (code == 4'b1111) |-> uncond_class && cond_pass);
   a_r7_failed_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (valid && !commit_en && flag_we) |=> $stable(flags_q));
   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (flags_q == 4'b0000));
endmodule

// File: tb/sim_cond_eval_unit.sv
module sim_cond_eval_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid;
   logic [31:0] instr;
   logic        flag_we;
   logic [3:0]  flag_new;
   logic        rd_we_req;
   logic        st_we_req;
   logic        cond_pass, uncond_class, commit_en, rd_we, st_we, suppress;
   logic [3:0]  flags_q;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   cond_eval_unit u0 (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer than 50000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected pass from the R1 table
   function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f);
      logic n, z, c, v, b;
      n = f[3]; z = f[2]; c = f[1]; v = f[0];
      case (cc[3:1])
         3'd0: b = z;
         3'd1: b = c;
         3'd2: b = n;
         3'd3: b = v;
         3'd4: b = c && !z;
         3'd5: b = (n == v);
         3'd6: b = !z && (n == v);
         default: return 1'b1;
      endcase
      return b ^ cc[0];
   endfunction

   // drive one instruction at the falling edge; outputs settle before the rising edge
   task automatic drive(input logic vld, input logic [3:0] cc, input logic fw,
                        input logic [3:0] fn, input logic rq, input logic sq);
      @(negedge clk);
      valid = vld; instr = {cc, 28'h0A5_5A5A}; flag_we = fw; flag_new = fn;
      rd_we_req = rq; st_we_req = sq;
      #1;
   endtask

   task automatic load_flags(input logic [3:0] f);
      drive(1'b1, 4'b1110, 1'b1, f, 1'b0, 1'b0);
   endtask

   initial begin
      logic [3:0] f_exp;
      logic       p_even;
      int         acc, exp_acc;
      rst = 1'b1; valid = 0; instr = 0; flag_we = 0; flag_new = 0;
      rd_we_req = 0; st_we_req = 0;
      repeat (3) @(negedge clk);
      // preload flags during reset: the reset must win
      flag_we = 1; valid = 1; instr = 32'hE000_0000; flag_new = 4'hF;
      @(negedge clk);
      rst = 1'b0; valid = 0; flag_we = 0;
      #1 chk("R8 reset flags", 32'(flags_q), 32'h0);

      // R5: idle cycle commits nothing
      drive(1'b0, 4'b1111, 1'b1, 4'hA, 1'b1, 1'b1);
      chk("R5 idle commit", 32'(commit_en), 0);
      chk("R6 idle suppress", 32'(suppress), 0);
      chk("R6 idle rd_we", 32'(rd_we), 0);
      @(negedge clk); #1 chk("R7 idle flag write ignored", 32'(flags_q), 0);

      // full sweep: 16 flag settings x 16 codes
      for (int f = 0; f < 16; f++) begin
         load_flags(4'(f));
         @(posedge clk); #1;
         chk("R7 flag load visible", 32'(flags_q), 32'(f));
         for (int cc = 0; cc < 16; cc++) begin
            logic ep, eu, ec;
            ep = ref_pass(4'(cc), 4'(f));
            eu = (cc == 15);
            ec = ep || eu;
            drive(1'b1, 4'(cc), 1'b0, 4'h0, cc[0], cc[1]);
            if (cc == 14) chk("R3 always code pass", 32'(cond_pass), 1);
            else if (cc == 15) chk("R4 top code pass", 32'(cond_pass), 1);
            else chk("R1 base test", 32'(cond_pass), 32'(ep));
            chk("R4 class flag", 32'(uncond_class), 32'(eu));
            chk("R5 commit", 32'(commit_en), 32'(ec));
            chk("R6 rd_we", 32'(rd_we), 32'(ec && cc[0]));
            chk("R6 st_we", 32'(st_we), 32'(ec && cc[1]));
            chk("R6 suppress", 32'(suppress), 32'(!ec));
            if (cc < 14) begin
               if (cc[0] == 1'b0) p_even = cond_pass;
               else chk("R2 pair complement", 32'(cond_pass), 32'(!p_even));
            end
         end
      end

      // R7: a failing instruction must not write flags
      load_flags(4'b0100);               // Z set
      drive(1'b1, 4'b0001, 1'b1, 4'b1011, 1'b0, 1'b0); // NE fails
      chk("R7 failing suppressed", 32'(suppress), 1);
      @(posedge clk); #1;
      chk("R7 failed flag write ignored", 32'(flags_q), 32'h4);
      drive(1'b1, 4'b0000, 1'b1, 4'b1011, 1'b0, 1'b0); // EQ passes
      @(posedge clk); #1;
      chk("R7 passing flag write lands", 32'(flags_q), 32'hB);
      drive(1'b1, 4'b1111, 1'b1, 4'b0010, 1'b0, 1'b0); // class 1111 writes
      @(posedge clk); #1;
      chk("R4 top code flag write", 32'(flags_q), 32'h2);

      // clamp: compare with 10, write 10 if higher-or-same, else add 1
      acc = 0; exp_acc = 0;
      for (int it = 0; it < 16; it++) begin
         logic [31:0] d;
         logic [3:0]  fc;
         logic        do_mov, do_add;
         d  = 32'(acc) - 32'd10;
         fc = {d[31], d == 0, 32'(acc) >= 32'd10,
               (acc[31] != 1'b0) && (d[31] != acc[31])};
         drive(1'b1, 4'b1110, 1'b1, fc, 1'b0, 1'b0);
         drive(1'b1, 4'b0010, 1'b0, 4'h0, 1'b1, 1'b0);
         do_mov = rd_we;
         drive(1'b1, 4'b0011, 1'b0, 4'h0, 1'b1, 1'b0);
         do_add = rd_we;
         if (do_mov) acc = 10;
         if (do_add) acc = acc + 1;
         exp_acc = (exp_acc >= 10) ? 10 : exp_acc + 1;
         chk("R7 clamp sequence", 32'(acc), 32'(exp_acc));
      end

      // reset again clears stored flags
      load_flags(4'hF);
      @(negedge clk); rst = 1'b1; valid = 0; flag_we = 0;
      @(negedge clk); rst = 1'b0; #1;
      chk("R8 reset after use", 32'(flags_q), 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule